// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a heartbeat line that the processor's software toggles. Each change of level on the line, whether rising or falling, restarts a timer. The timer advances only on cycles where a clock-enable tick is present. If the line stays at one level for a set number of ticks, the active-low watchdog output goes low. The output stays low until the next heartbeat transition restarts the timer.

A reset-active flag holds the timer at zero, so the first timeout period begins only after reset is released. A supply-low flag pulls the output low whatever the timer state is. A disable flag represents a heartbeat pin that has been left unconnected. While it is set, the disable flag keeps the timer at zero and holds the output high. The heartbeat line is asynchronous and passes through a flop synchronizer. The other three flags are synchronous to `clk_i`. The timeout is a tick-count parameter. A 1 kHz tick with the default of 1600 gives the nominal 1.6 s period. An allowed window runs from 1.0 s to 2.25 s, so a coarser tick also fits.

Top module: `edge_wdog`

## Requirements
- R1: After `rst_ni` is released, with the other inputs idle, `wdo_no` is 1 and the timer count is zero.
- R2: A rising transition on `hb_i` clears the timer. The clear takes effect on the third clock edge after the transition.
- R3: A falling transition on `hb_i` clears the timer in the same way as a rising one.
- R4: Suppose `hb_i` holds its level and `TIMEOUT_TICKS` ticks arrive with no clear. Then `wdo_no` goes to 0 one cycle after the clock edge that samples the last of those ticks.
- R5: After a timeout, `wdo_no` stays 0 until an `hb_i` transition, reset or disable clears the timer. After a transition it returns to 1.
- R6: While `sys_rst_i` is 1, the timer is held at zero and no timeout can occur. The timeout period starts counting on the first tick after `sys_rst_i` returns to 0.
- R7: When `supply_low_i` is 1, `wdo_no` is 0 on the next cycle, whatever the timer state. When it returns to 0, `wdo_no` returns to 1 on the next cycle, provided the timer has not expired.
- R8: When `disable_i` is 1, the timer is cleared and `wdo_no` is 1 on the next cycle. The exception is when `supply_low_i` is also 1, in which case `wdo_no` is 0.
- R9: A heartbeat pulse of one clock period restarts the timer just as a level change does.
- R10: The timer advances only on cycles with `tick_i` equal to 1. With no ticks, no timeout occurs, however long the heartbeat stays still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hb_i | input | 1 | Heartbeat line (asynchronous) |
| disable_i | input | 1 | Watchdog disabled (line unconnected) |
| supply_low_i | input | 1 | Supply below threshold |
| sys_rst_i | input | 1 | System reset active, holds the timer clear |
| tick_i | input | 1 | Timebase enable, one cycle wide |
| wdo_no | output | 1 | Watchdog flag, low on timeout or low supply |

## Verification
The bench lets the heartbeat go quiet just short of the limit and then toggles it. A design that clears on only one edge direction, or that misses a one-cycle pulse, would time out at that point. The bench then waits well past the limit to catch a timer that never expires. It also confirms the low output does not release by itself, which exposes an output that is not sticky. The flag cases check for three faults: supply-low failing to override disable, disable or reset failing to restart the period from zero, and a timer that counts clock cycles instead of ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_SUPPLY   = 2'd0,
    SRC_DISABLED = 2'd1,
    SRC_TIMER    = 2'd2
  } wdo_src_e;
endpackage

// File: rtl/wdt_hb_sync.sv
module wdt_hb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= hb_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], hb_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  // either direction counts
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned LIMIT = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && !exp_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = exp_q;

  // R10
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exp_q) |-> $past(tick_i));
  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q && !clr_i |=> exp_q);
  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !exp_q && cnt_q == '0);
endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic disable_i,
  input  logic expired_i,
  output logic wdo_no
);
  wdo_src_e src;
  logic     wdo_q;

  always_comb begin
    if (supply_low_i)   src = SRC_SUPPLY;
    else if (disable_i) src = SRC_DISABLED;
    else                src = SRC_TIMER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdo_q <= 1'b1;
    else begin
      unique case (src)
        SRC_SUPPLY:   wdo_q <= 1'b0;
        SRC_DISABLED: wdo_q <= 1'b1;
        default:      wdo_q <= ~expired_i;
      endcase
    end
  end

  assign wdo_no = wdo_q;

  // R7
  supply_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |=> !wdo_no);
  // R8
  disable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i && !supply_low_i |=> wdo_no);
  // R4
  timeout_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_i && !supply_low_i && !disable_i |=> !wdo_no);
endmodule

// File: rtl/edge_wdog.sv
module edge_wdog #(
  parameter int unsigned TIMEOUT_TICKS = 1600,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  input  logic disable_i,
  input  logic supply_low_i,
  input  logic sys_rst_i,
  input  logic tick_i,
  output logic wdo_no
);
  logic hb_edge;
  logic tmr_clr;
  logic expired;

  wdt_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hb_i   (hb_i),
    .edge_o (hb_edge)
  );

  assign tmr_clr = hb_edge | sys_rst_i | disable_i;

  wdt_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .tick_i    (tick_i),
    .expired_o (expired)
  );

  wdt_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_low_i (supply_low_i),
    .disable_i    (disable_i),
    .expired_i    (expired),
    .wdo_no       (wdo_no)
  );
endmodule

// File: tb/edge_wdog_bench.sv
module edge_wdog_bench;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hb = 1'b0, dis = 1'b0, slow = 1'b0, srst = 1'b1, tick = 1'b1;
  logic wdo_n;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  edge_wdog #(.TIMEOUT_TICKS(T)) u_edge_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .hb_i(hb), .disable_i(dis),
    .supply_low_i(slow), .sys_rst_i(srst), .tick_i(tick), .wdo_no(wdo_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (wdo_n !== exp) begin
      failures++;
      $display("FAIL %s wdo_no actual=%b expected=%b at %0t", req, wdo_n, exp, $time);
    end
  endtask

  task automatic restart();
    srst = 1'b1; cyc(2); srst = 1'b0;
  endtask

  task automatic t_reset_state();
    cyc(3); rst_ni = 1'b1; cyc(2);
    check(1'b1, "R1");
  endtask

  task automatic t_timeout_sticky();
    restart();
    cyc(T - 1); check(1'b1, "R4 before limit");
    cyc(4);     check(1'b0, "R4 after limit");
    cyc(10);    check(1'b0, "R5 stays low");
    hb = ~hb; cyc(5); check(1'b1, "R5 transition restores");
  endtask

  task automatic t_edge(input logic lvl, input string req);
    hb = ~lvl; restart(); cyc(4);
    restart();
    cyc(T - 5); hb = lvl;
    cyc(T - 3); check(1'b1, req);
    cyc(8);     check(1'b0, req);
  endtask

  task automatic t_pulse();
    restart();
    cyc(T - 5); hb = ~hb; cyc(1); hb = ~hb;
    cyc(T - 3); check(1'b1, "R9 short pulse");
  endtask

  task automatic t_sysrst();
    srst = 1'b1; cyc(3 * T); check(1'b1, "R6 held");
    srst = 1'b0;
    cyc(T - 1); check(1'b1, "R6 fresh period");
    cyc(4);     check(1'b0, "R6 expiry after release");
  endtask

  task automatic t_supply();
    restart();
    slow = 1'b1; cyc(2); check(1'b0, "R7 forced low");
    slow = 1'b0; cyc(2); check(1'b1, "R7 released");
  endtask

  task automatic t_disable();
    restart(); cyc(T + 3); check(1'b0, "R8 pre expired");
    dis = 1'b1; cyc(2); check(1'b1, "R8 clears expiry");
    cyc(3 * T); check(1'b1, "R8 no timeout");
    slow = 1'b1; cyc(2); check(1'b0, "R8 supply wins");
    slow = 1'b0; cyc(2); check(1'b1, "R8 back high");
    dis = 1'b0;
    cyc(T - 1); check(1'b1, "R8 fresh period");
    cyc(4);     check(1'b0, "R8 expiry after enable");
  endtask

  task automatic t_tick();
    restart(); tick = 1'b0;
    cyc(3 * T); check(1'b1, "R10 no ticks");
    tick = 1'b1;
    cyc(T + 3); check(1'b0, "R10 ticks resume");
  endtask

  initial begin
    t_reset_state();
    t_timeout_sticky();
    t_edge(1'b1, "R2 rising");
    t_edge(1'b0, "R3 falling");
    t_pulse();
    t_sysrst();
    t_supply();
    t_disable();
    t_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule